// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Transmitter

This block sends bytes over a clocked synchronous serial link. A host writes a byte into a holding register. The block moves it into a separate shift register as soon as the shifter is free, and then drives the bits onto a data pin, least significant bit first. Because the holding register and the shift register are separate, the host can write the next byte while the current one is still on the line. When the host keeps up, frames follow each other with no idle clock period between them.

The serial clock has two sources. In internal mode the block drives its own clock pin from a system-clock divider: eight pulses per byte, the pin high between frames, and data changing while the clock is low. In external mode the clock pin stays high and the block follows a clock input, which passes through a two-flop synchronizer. Each synchronized falling edge advances the data by one bit, and a frame starts on a falling edge.

Two flags report progress: "holding register empty" and "transmission ended". Each flag has its own interrupt request output, gated by an enable input. Three receive-error inputs (overrun, framing, parity) hold off any new frame while one of them is high. The clock-source select must only change while the block is idle.

Top module: `sync_serial_tx`

## Requirements
- R1: After reset `buf_empty`=1, `tx_end`=1, `sclk_out`=1 and `sdata_out`=1. No clock pulse is produced until a byte is written.
- R2: A cycle with `wr_en`=1 stores `wr_data` and clears both `buf_empty` and `tx_end` at that clock edge.
- R3: When `buf_empty`=0 and no `rx_err` bit is set, the stored byte moves into the shifter, `buf_empty` returns to 1 and the frame starts. In internal mode this is the next clock edge.
- R4: Bits leave LSB first: bit 0 through bit 7 are the `sdata_out` values seen at rising edges 1 to 8 of the frame. In internal mode `sdata_out` changes only in cycles where `sclk_out` is low.
- R5: In internal mode each frame gives exactly 8 pulses on `sclk_out`, with a period of 2*HALF_DIV system cycles (low half first). `sclk_out` is high outside frames.
- R6: In external mode (`ext_clk_sel`=1) `sclk_out` stays high. Each synchronized falling edge of `sclk_in` puts the next bit on `sdata_out`, and the first falling edge after the conditions of R3 hold starts the frame with bit 0.
- R7: If `buf_empty` is 0 when bit 7 goes onto the line, the next byte is loaded there and its bit 0 follows bit 7 with no gap. The interval between rising edges stays 2*HALF_DIV cycles.
- R8: If `buf_empty` is 1 when bit 7 goes onto the line, `tx_end` is set. After the frame `sdata_out` keeps the bit 7 value and `sclk_out` stays high.
- R9: `irq_buf_empty` is 1 exactly when `buf_empty`=1 and `buf_irq_en`=1.
- R10: `irq_tx_end` is 1 exactly when `tx_end`=1 and `end_irq_en`=1.
- R11: While any bit of `rx_err` is 1, no frame starts: the byte stays held, `buf_empty` stays 0 and `sclk_out` stays high. The frame starts once `rx_err` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | DATA_W | Byte written by the host |
| buf_irq_en | input | 1 | Enable for the buffer-empty interrupt |
| end_irq_en | input | 1 | Enable for the transmission-end interrupt |
| ext_clk_sel | input | 1 | 1 = follow sclk_in, 0 = internal divider |
| sclk_in | input | 1 | External serial clock |
| rx_err | input | ERR_W | Receive error flags (overrun, framing, parity) |
| sclk_out | output | 1 | Serial clock output, parks high |
| sdata_out | output | 1 | Serial data output |
| buf_empty | output | 1 | Holding register empty flag |
| tx_end | output | 1 | Transmission ended flag |
| irq_buf_empty | output | 1 | Buffer-empty interrupt request |
| irq_tx_end | output | 1 | Transmission-end interrupt request |

## Verification
The bench goes after the chaining decision by writing a second byte during the first frame. If the decision is made too late, a clock period is lost between the two frames; if it is made too early or not at all, the second byte never appears. Single frames ending in 1 and in 0 check that the line keeps bit 7 and that the clock parks high; a design that returns the line to a fixed level, or that gives a ninth pulse, fails here. Other tests hold an error input high across a write to catch a design that starts anyway, follow a slow external clock to catch bits shifted on the wrong edge or a clock pin that is not held high, and toggle the interrupt enables around flag changes.

// File: rtl/sstx_pkg.sv
package sstx_pkg;

  // Events the shift engine reports to the flag registers.
  typedef struct packed {
    logic load;     // holding register moved into the shifter
    logic end_set;  // last bit started with nothing queued
  } tx_evt_t;

  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;

endpackage

// File: rtl/sstx_clkgen.sv
module sstx_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_mode,
  input  logic sclk_in,
  input  logic run,
  input  logic go_low,
  output logic fall_evt,
  output logic sclk_out
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(HALF_DIV - 1);

  logic [CW-1:0] div_q, div_d;
  logic          sclk_q, sclk_d;
  logic [1:0]    sync_q, sync_d;
  logic          prev_q, prev_d;
  logic          tick;
  logic          ext_fall;

  assign tick     = run && (div_q == LAST_CNT);
  assign ext_fall = prev_q && !sync_q[1];
  assign fall_evt = ext_mode ? ext_fall : (tick && sclk_q);
  assign sclk_out = sclk_q;

  always_comb begin
    if (go_low || !run || tick) div_d = '0;
    else                        div_d = div_q + CW'(1);

    sclk_d = sclk_q;
    if (ext_mode)                sclk_d = 1'b1;
    else if (go_low)             sclk_d = 1'b0;
    else if (tick && !sclk_q)    sclk_d = 1'b1;

    sync_d = {sync_q[0], sclk_in};
    prev_d = sync_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
      sync_q <= 2'b11;
      prev_q <= 1'b1;
    end else begin
      div_q  <= div_d;
      sclk_q <= sclk_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/sstx_engine.sv
module sstx_engine
  import sstx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              fall_evt,
  input  logic              buf_empty,
  input  logic              err_any,
  input  logic [DATA_W-1:0] hold_data,
  output logic              active,
  output logic              go_low,
  output tx_evt_t           evt,
  output logic              sdata
);
  localparam int BCW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [BCW-1:0] LAST_IDX  = BCW'(DATA_W - 1);
  localparam logic [BCW-1:0] CHECK_IDX = BCW'(DATA_W - 2);

  logic [DATA_W-1:0] tsr_q, tsr_d;
  logic [BCW-1:0]    cnt_q, cnt_d, nxt_idx;
  logic              act_q, act_d;
  logic              chain_q, chain_d;
  logic              sdata_q, sdata_d;
  logic              ready, start, step, last, check, cont;

  assign ready   = !buf_empty && !err_any;
  assign start   = !act_q && ready && (ext_mode ? fall_evt : 1'b1);
  assign step    = act_q && fall_evt;
  assign last    = (cnt_q == LAST_IDX);
  assign check   = (cnt_q == CHECK_IDX);
  assign cont    = step && (!last || chain_q);
  assign nxt_idx = cnt_q + BCW'(1);

  assign go_low      = !ext_mode && (start || cont);
  assign evt.load    = start || (step && check && ready);
  assign evt.end_set = step && check && buf_empty;
  assign active      = act_q;
  assign sdata       = sdata_q;

  always_comb begin
    tsr_d   = tsr_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    chain_d = chain_q;
    sdata_d = sdata_q;
    if (start) begin
      tsr_d   = hold_data;
      sdata_d = hold_data[0];
      cnt_d   = '0;
      act_d   = 1'b1;
      chain_d = 1'b0;
    end else if (step) begin
      if (last) begin
        if (chain_q) begin
          sdata_d = tsr_q[0];
          cnt_d   = '0;
          chain_d = 1'b0;
        end else begin
          act_d = 1'b0;
        end
      end else begin
        cnt_d   = nxt_idx;
        sdata_d = tsr_q[nxt_idx];
        if (check && ready) begin
          tsr_d   = hold_data;
          chain_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsr_q   <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
      chain_q <= 1'b0;
      sdata_q <= 1'b1;
    end else begin
      tsr_q   <= tsr_d;
      cnt_q   <= cnt_d;
      act_q   <= act_d;
      chain_q <= chain_d;
      sdata_q <= sdata_d;
    end
  end
endmodule

// File: rtl/sstx_regs.sv
module sstx_regs
  import sstx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  tx_evt_t           evt,
  input  logic              buf_irq_en,
  input  logic              end_irq_en,
  output logic [DATA_W-1:0] hold_data,
  output logic              buf_empty,
  output logic              tx_end,
  output logic              irq_buf_empty,
  output logic              irq_tx_end
);
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              be_q, be_d;
  logic              te_q, te_d;

  always_comb begin
    hold_d = wr_en ? wr_data : hold_q;

    if (wr_en)         be_d = 1'b0;
    else if (evt.load) be_d = 1'b1;
    else               be_d = be_q;

    if (wr_en)            te_d = 1'b0;
    else if (evt.end_set) te_d = 1'b1;
    else                  te_d = te_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      be_q   <= 1'b1;
      te_q   <= 1'b1;
    end else begin
      hold_q <= hold_d;
      be_q   <= be_d;
      te_q   <= te_d;
    end
  end

  assign hold_data     = hold_q;
  assign buf_empty     = be_q;
  assign tx_end        = te_q;
  assign irq_buf_empty = be_q && buf_irq_en;
  assign irq_tx_end    = te_q && end_irq_en;
endmodule

// File: rtl/sync_serial_tx.sv
module sync_serial_tx
  import sstx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ERR_W    = 3,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              buf_irq_en,
  input  logic              end_irq_en,
  input  logic              ext_clk_sel,
  input  logic              sclk_in,
  input  logic [ERR_W-1:0]  rx_err,
  output logic              sclk_out,
  output logic              sdata_out,
  output logic              buf_empty,
  output logic              tx_end,
  output logic              irq_buf_empty,
  output logic              irq_tx_end
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [DATA_W-1:0] hold_data;
  logic              active, go_low, fall_evt, err_any, ext_mode;
  tx_evt_t           evt;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign err_any  = |rx_err;
  assign ext_mode = (clk_src_e'(ext_clk_sel) == SRC_EXT);

  sstx_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ext_mode (ext_mode),
    .sclk_in  (sclk_in),
    .run      (active),
    .go_low   (go_low),
    .fall_evt (fall_evt),
    .sclk_out (sclk_out)
  );

  sstx_engine #(.DATA_W(DATA_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .ext_mode  (ext_mode),
    .fall_evt  (fall_evt),
    .buf_empty (buf_empty),
    .err_any   (err_any),
    .hold_data (hold_data),
    .active    (active),
    .go_low    (go_low),
    .evt       (evt),
    .sdata     (sdata_out)
  );

  sstx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .evt           (evt),
    .buf_irq_en    (buf_irq_en),
    .end_irq_en    (end_irq_en),
    .hold_data     (hold_data),
    .buf_empty     (buf_empty),
    .tx_end        (tx_end),
    .irq_buf_empty (irq_buf_empty),
    .irq_tx_end    (irq_tx_end)
  );
endmodule

// File: rtl/sync_serial_tx_chk.sv
module sync_serial_tx_chk #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              buf_irq_en,
  input logic              end_irq_en,
  input logic              ext_clk_sel,
  input logic              sclk_in,
  input logic [ERR_W-1:0]  rx_err,
  input logic              sclk_out,
  input logic              sdata_out,
  input logic              buf_empty,
  input logic              tx_end,
  input logic              irq_buf_empty,
  input logic              irq_tx_end
);
  // Arms a few cycles after reset release, once the core is out of reset.
  logic [2:0] arm_q;
  logic       armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 3'b000;
    else        arm_q <= {arm_q[1:0], 1'b1};
  end
  assign armed = arm_q[2];

  assert_write_clears_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    wr_en |=> (!buf_empty && !tx_end));

  assert_data_moves_low_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!ext_clk_sel && $past(!ext_clk_sel) && !$stable(sdata_out)) |-> !sclk_out);

  assert_ext_clk_parked_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (ext_clk_sel && $past(ext_clk_sel)) |-> sclk_out);

  assert_end_needs_empty_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $rose(tx_end) |-> buf_empty);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !buf_empty |-> !irq_buf_empty);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !end_irq_en |-> !irq_tx_end);

  assert_err_holds_R11: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ((|rx_err) && !buf_empty) |=> !buf_empty);
endmodule

bind sync_serial_tx sync_serial_tx_chk #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_chk (.*);

// File: tb/sync_serial_tx_test.sv
`timescale 1ns/1ps
module sync_serial_tx_test;
  localparam int HD = 4;
  localparam int PER = 2 * HD;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       buf_irq_en = 1'b0, end_irq_en = 1'b0;
  logic       ext_clk_sel = 1'b0, sclk_in = 1'b1;
  logic [2:0] rx_err = '0;
  logic       sclk_out, sdata_out, buf_empty, tx_end, irq_buf_empty, irq_tx_end;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sync_serial_tx #(.DATA_W(8), .ERR_W(3), .HALF_DIV(HD)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .buf_irq_en(buf_irq_en), .end_irq_en(end_irq_en),
    .ext_clk_sel(ext_clk_sel), .sclk_in(sclk_in), .rx_err(rx_err),
    .sclk_out(sclk_out), .sdata_out(sdata_out), .buf_empty(buf_empty),
    .tx_end(tx_end), .irq_buf_empty(irq_buf_empty), .irq_tx_end(irq_tx_end));

  // Rising-edge monitor on the serial clock, sampled mid-cycle.
  int   cyc = 0, nrise = 0;
  logic rbit [0:127];
  int   rtime [0:127];
  logic prev_s = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (!prev_s && sclk_out && nrise < 128) begin
      rbit[nrise]  = sdata_out;
      rtime[nrise] = cyc;
      nrise++;
    end
    prev_s = sclk_out;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int frame_at(input int base);
    int v = 0;
    for (int i = 0; i < 8; i++) v = v | (int'(rbit[base + i]) << i);
    return v;
  endfunction

  task automatic t_reset();
    chk("R1 buf_empty", buf_empty, 1);
    chk("R1 tx_end", tx_end, 1);
    chk("R1 sclk_out", sclk_out, 1);
    chk("R1 sdata_out", sdata_out, 1);
    repeat (20) @(negedge clk);
    chk("R1 no pulses", nrise, 0);
  endtask

  task automatic t_single(input logic [7:0] b);
    int base = nrise;
    write_byte(b);
    chk("R2 buf_empty after write", buf_empty, 0);
    chk("R2 tx_end after write", tx_end, 0);
    @(negedge clk);
    chk("R3 buf_empty after load", buf_empty, 1);
    repeat (PER * 8 + 20) @(negedge clk);
    chk("R5 pulse count", nrise - base, 8);
    chk("R4 frame bits", frame_at(base), int'(b));
    chk("R5 pulse period", rtime[base + 7] - rtime[base + 6], PER);
    chk("R8 tx_end", tx_end, 1);
    chk("R8 line holds bit7", sdata_out, int'(b[7]));
    chk("R8 clock parked", sclk_out, 1);
  endtask

  task automatic t_chain(input logic [7:0] b1, input logic [7:0] b2);
    int base = nrise;
    write_byte(b1);
    repeat (4) @(negedge clk);
    write_byte(b2);
    chk("R7 tx_end cleared mid frame", tx_end, 0);
    repeat (PER * 16 + 20) @(negedge clk);
    chk("R7 pulse count", nrise - base, 16);
    chk("R7 first byte", frame_at(base), int'(b1));
    chk("R7 second byte", frame_at(base + 8), int'(b2));
    chk("R7 no gap", rtime[base + 8] - rtime[base + 7], PER);
    chk("R8 tx_end after chain", tx_end, 1);
    chk("R8 holds bit7 of second", sdata_out, int'(b2[7]));
  endtask

  task automatic t_error(input logic [7:0] b);
    int base = nrise;
    rx_err = 3'b010;
    write_byte(b);
    repeat (60) @(negedge clk);
    chk("R11 no pulses while error", nrise - base, 0);
    chk("R11 byte still held", buf_empty, 0);
    chk("R11 clock high", sclk_out, 1);
    rx_err = 3'b000;
    repeat (PER * 8 + 20) @(negedge clk);
    chk("R11 sent after clear", frame_at(base), int'(b));
    chk("R11 pulse count after clear", nrise - base, 8);
  endtask

  task automatic t_ext(input logic [7:0] b);
    int got = 0;
    int hi_ok = 1;
    ext_clk_sel = 1'b1;
    repeat (4) @(negedge clk);
    write_byte(b);
    repeat (4) @(negedge clk);
    chk("R6 no start without edge", buf_empty, 0);
    for (int i = 0; i < 9; i++) begin
      sclk_in = 1'b0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (!sclk_out) hi_ok = 0;
      end
      if (i < 8) got = got | (int'(sdata_out) << i);
      sclk_in = 1'b1;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (!sclk_out) hi_ok = 0;
      end
    end
    chk("R6 external frame bits", got, int'(b));
    chk("R6 clock pin held high", hi_ok, 1);
    chk("R8 ext holds bit7", sdata_out, int'(b[7]));
    chk("R8 ext tx_end", tx_end, 1);
    ext_clk_sel = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_irq(input logic [7:0] b);
    buf_irq_en = 1'b1; end_irq_en = 1'b1;
    @(negedge clk);
    chk("R9 irq idle", irq_buf_empty, 1);
    chk("R10 irq idle", irq_tx_end, 1);
    write_byte(b);
    chk("R9 irq after write", irq_buf_empty, 0);
    chk("R10 irq after write", irq_tx_end, 0);
    @(negedge clk);
    chk("R9 irq after load", irq_buf_empty, 1);
    repeat (PER * 8 + 20) @(negedge clk);
    chk("R10 irq at end", irq_tx_end, 1);
    buf_irq_en = 1'b0; end_irq_en = 1'b0;
    @(negedge clk);
    chk("R9 irq disabled", irq_buf_empty, 0);
    chk("R10 irq disabled", irq_tx_end, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset();
    t_single(8'hA5);
    t_single(8'h4B);
    t_chain(8'h3C, 8'hC3);
    t_error(8'h96);
    t_ext(8'hD2);
    t_irq(8'h5A);
    summary();
  end
endmodule